// File: doc/BRIEF.md
# Control-Word Steered Register Datapath

This block is a small bus-organized datapath. It holds seven general registers and executes one microoperation per clock. A single 14-bit control word steers every part of the datapath, so no instruction decoder is needed. Two eight-way multiplexers pick the operands for bus A and bus B. A multi-function ALU combines the two bus values. A destination decoder then enables exactly one register to capture the ALU output on the next rising edge.

The ALU result and three status flags are combinational outputs of the current control word. The flags are zero, negative and carry/borrow. A surrounding sequencer reads these outputs in the same cycle. Select code zero on either bus routes the external input word onto that bus, and this is how fresh data enters the register file.

The control word is qualified by `cw_valid`. There is no back-pressure: the block accepts a valid word on every cycle, and no ready signal exists. When `cw_valid` is low, nothing is stored.

Top module: `microop_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears all seven registers to zero at the rising edge. Reset takes priority over any write in the same cycle.
- R2: The control word is split by bit position into source A `cw[13:11]`, source B `cw[10:8]`, destination `cw[7:5]` and operation `cw[4:0]`. For example, `14'b010_011_001_00101` stores register 2 minus register 3 into register 1.
- R3: Select code 0 on either source field puts `in_data` on that bus. Codes 1 to 7 put the matching register on that bus. Both buses are read in the same cycle.
- R4: When `cw_valid` is high and the destination code k is between 1 and 7, only register k loads `result` at the rising edge. Destination code 0 loads no register.
- R5: When `cw_valid` is low, no register changes. The block never stalls the control word stream.
- R6: The arithmetic operation codes are:
  - 00000: pass A.
  - 00001: A+1.
  - 00010: A+B.
  - 00101: A−B.
  - 00110: A−1.
  All results wrap modulo 2^W.
- R7: The logic operation codes are 01000 AND, 01010 OR, 01100 XOR and 01110 bitwise complement of A.
- R8: Code 10000 shifts A right by one bit, filling with zero. Code 11000 shifts A left by one bit, filling with zero.
- R9: Any other operation code passes A through unchanged, with carry 0.
- R10: `flag_z` is 1 exactly when `result` is zero, and `flag_n` equals the top bit of `result`. `flag_c` depends on the operation:
  - Add and increment: the carry out.
  - Subtract: 1 when A < B.
  - Decrement: 1 when A is 0.
  - Shift right: the bit shifted out of bit 0.
  - Shift left: the bit shifted out of the top bit.
  - All other codes: 0.
- R11: `result` and the flags reflect the current control word and bus values in the same cycle. A stored value becomes visible on the buses from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Qualifies the control word; low means no register write |
| cw | input | 14 | Packed control word {srcA, srcB, dst, op} |
| in_data | input | W | External input word, selected by source code 0 |
| result | output | W | ALU output for the current control word |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry or borrow of the current operation |
| flag_n | output | 1 | Top bit of the result |

## Verification
The case of interest is a register that is both a source and the destination of the same word. In that cycle, the bus must deliver the old contents while the decoder loads the new value.

The bench sweeps every source A and source B pair for every operation code. It rotates the destination so that it often equals one of the sources, including code 0. Each result is compared with a bench-side register model. The next word reading that register then confirms that the write landed only after the edge.

// File: rtl/microop_pkg.sv
package microop_pkg;
  localparam int SEL_W = 3;
  localparam int OP_W  = 5;
  localparam int CW_W  = 3 * SEL_W + OP_W;
  localparam int NREG  = (1 << SEL_W) - 1;

  typedef logic [OP_W-1:0] op_t;
  localparam op_t OP_PASS = 5'b00000;
  localparam op_t OP_INC  = 5'b00001;
  localparam op_t OP_ADD  = 5'b00010;
  localparam op_t OP_SUB  = 5'b00101;
  localparam op_t OP_DEC  = 5'b00110;
  localparam op_t OP_AND  = 5'b01000;
  localparam op_t OP_OR   = 5'b01010;
  localparam op_t OP_XOR  = 5'b01100;
  localparam op_t OP_NOT  = 5'b01110;
  localparam op_t OP_SHR  = 5'b10000;
  localparam op_t OP_SHL  = 5'b11000;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    op_t              op;
  } ctl_word_t;
endpackage

// File: rtl/microop_dec.sv
module microop_dec
  import microop_pkg::*;
(
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NREG:1]    load
);
  for (genvar i = 1; i <= NREG; i++) begin : g_line
    assign load[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/microop_regfile.sv
module microop_regfile
  import microop_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREG:1]    load,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     ext,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  output logic [W-1:0]     bus_a,
  output logic [W-1:0]     bus_b
);
  logic [W-1:0] q [1:NREG];

  for (genvar i = 1; i <= NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)          q[i] <= '0;
      else if (load[i]) q[i] <= wdata;
    end
  end

  always_comb begin
    bus_a = ext;
    bus_b = ext;
    for (int k = 1; k <= NREG; k++) begin
      if (sel_a == SEL_W'(k)) bus_a = q[k];
      if (sel_b == SEL_W'(k)) bus_b = q[k];
    end
  end
endmodule

// File: rtl/microop_alu.sv
module microop_alu
  import microop_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_t          op,
  output logic [W-1:0] y,
  output logic         c,
  output logic         z,
  output logic         n
);
  localparam logic [W:0] ONE = (W+1)'(1);

  always_comb begin
    y = a;
    c = 1'b0;
    case (op)
      OP_PASS: y = a;
      OP_INC:  {c, y} = {1'b0, a} + ONE;
      OP_ADD:  {c, y} = {1'b0, a} + {1'b0, b};
      OP_SUB:  {c, y} = {1'b0, a} - {1'b0, b};
      OP_DEC:  {c, y} = {1'b0, a} - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  begin y = {1'b0, a[W-1:1]}; c = a[0]; end
      OP_SHL:  begin y = {a[W-2:0], 1'b0}; c = a[W-1]; end
      default: begin y = a; c = 1'b0; end
    endcase
    z = (y == '0);
    n = y[W-1];
  end
endmodule

// File: rtl/microop_datapath.sv
module microop_datapath
  import microop_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cw_valid,
  input  logic [CW_W-1:0] cw,
  input  logic [W-1:0]    in_data,
  output logic [W-1:0]    result,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_n
);
  ctl_word_t     word;
  logic [NREG:1] we;
  logic [W-1:0]  bus_a, bus_b;

  assign word = ctl_word_t'(cw);

  microop_dec u_dec (
    .en   (cw_valid),
    .sel  (word.dst),
    .load (we)
  );

  microop_regfile #(.W(W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .load  (we),
    .wdata (result),
    .ext   (in_data),
    .sel_a (word.src_a),
    .sel_b (word.src_b),
    .bus_a (bus_a),
    .bus_b (bus_b)
  );

  microop_alu #(.W(W)) u_alu (
    .a  (bus_a),
    .b  (bus_b),
    .op (word.op),
    .y  (result),
    .c  (flag_c),
    .z  (flag_z),
    .n  (flag_n)
  );
endmodule

// File: rtl/microop_datapath_chk.sv
module microop_datapath_chk
  import microop_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cw_valid,
  input logic [CW_W-1:0] cw,
  input logic [W-1:0]    result,
  input logic            flag_z,
  input logic [W-1:0]    bus_a,
  input logic [NREG:1]   we
);
  // R4
  we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cw[13:11] != '0) |-> bus_a == '0);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cw_valid) && cw[13:11] != '0
     && cw[13:11] == $past(cw[13:11])) |-> bus_a == $past(bus_a));

  // R11
  write_seen_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cw_valid) && $past(cw[7:5]) != '0
     && cw[13:11] == $past(cw[7:5])) |-> bus_a == $past(result));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_z == (result == '0));
endmodule

bind microop_datapath microop_datapath_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cw_valid (cw_valid),
  .cw       (cw),
  .result   (result),
  .flag_z   (flag_z),
  .bus_a    (bus_a),
  .we       (we)
);

// File: tb/microop_datapath_test.sv
module microop_datapath_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cw_valid = 1'b0;
  logic [13:0]  cw = '0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] result;
  logic         flag_z, flag_c, flag_n;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [W-1:0] m [1:7];

  always #10 clk = ~clk;

  microop_datapath #(.W(W)) uut (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw(cw), .in_data(in_data),
    .result(result), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model of the ALU: returns {carry, result}
  function automatic logic [W:0] model(input logic [4:0] op, input int a, input int b);
    int y; int c;
    c = 0;
    case (op)
      5'b00000: y = a;
      5'b00001: begin y = a + 1; c = (y > 255); end
      5'b00010: begin y = a + b; c = (y > 255); end
      5'b00101: begin y = a - b; c = (a < b); end
      5'b00110: begin y = a - 1; c = (a == 0); end
      5'b01000: y = a & b;
      5'b01010: y = a | b;
      5'b01100: y = a ^ b;
      5'b01110: y = 255 - a;
      5'b10000: begin y = a / 2; c = a % 2; end
      5'b11000: begin y = a * 2; c = (a >= 128); end
      default:  y = a;
    endcase
    return {c[0], y[W-1:0]};
  endfunction

  function automatic string optag(input logic [4:0] op);
    case (op)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R6";
      5'b01000, 5'b01010, 5'b01100, 5'b01110: return "R7";
      5'b10000, 5'b11000: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Drive one word shortly after a rising edge, check at mid-cycle, commit at next edge
  task automatic exec_raw(input bit v, input logic [13:0] w, input logic [W-1:0] din);
    int a; int b; logic [W:0] e; logic [2:0] sa, sb, sd; logic [4:0] op;
    sa = w[13:11]; sb = w[10:8]; sd = w[7:5]; op = w[4:0];
    cw_valid = v; cw = w; in_data = din;
    a = (sa == 0) ? int'(din) : int'(m[sa]);
    b = (sb == 0) ? int'(din) : int'(m[sb]);
    e = model(op, a, b);
    #8;
    chk(result == e[W-1:0], {optag(op), " R3 R11 result"}, result, e[W-1:0]);
    chk({flag_c, flag_z, flag_n} == {e[W], e[W-1:0] == 0, e[W-1]},
        "R10 flags", {flag_c, flag_z, flag_n}, {e[W], e[W-1:0] == 0, e[W-1]});
    @(posedge clk);
    if (v && sd != 0) m[sd] = e[W-1:0];
    #1;
  endtask

  task automatic exec(input bit v, input int sa, input int sb, input int sd,
                      input logic [4:0] op, input logic [W-1:0] din);
    exec_raw(v, {sa[2:0], sb[2:0], sd[2:0], op}, din);
  endtask

  task automatic read_all(input string tag);
    for (int k = 1; k <= 7; k++) begin
      cw_valid = 1'b0; cw = {k[2:0], 3'd0, 3'd0, 5'b00000}; in_data = 8'hA5;
      #8;
      chk(result == m[k], tag, result, m[k]);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    for (int k = 1; k <= 7; k++) m[k] = '0;
    // R1: reset wins over a write in the same cycle
    cw_valid = 1'b1; cw = {3'd0, 3'd0, 3'd4, 5'b00000}; in_data = 8'h77;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; cw_valid = 1'b0;
    read_all("R1 reset value");

    // R4: load each register through the input port
    for (int k = 1; k <= 7; k++) exec(1, 0, 0, k, 5'b00000, W'(k * 37 + 3));
    read_all("R4 load");

    // R2: packed example word, R1 <- R2 - R3
    exec(1, 0, 0, 2, 5'b00000, 8'h37);
    exec(1, 0, 0, 3, 5'b00000, 8'h12);
    exec_raw(1, 14'b010_011_001_00101, 8'h00);
    chk(m[1] == 8'h25, "R2 model", m[1], 8'h25);
    read_all("R2 field order");

    // R5: invalid word leaves registers alone
    exec(0, 0, 0, 4, 5'b00010, 8'hEE);
    exec(0, 1, 2, 5, 5'b01110, 8'h00);
    read_all("R5 idle");

    // R4: destination 0 writes nothing
    exec(1, 0, 0, 0, 5'b00000, 8'h99);
    read_all("R4 dst zero");

    // R10 boundaries: wrap on add, borrow, decrement of zero, shift outs
    exec(1, 0, 0, 6, 5'b00000, 8'hFF);
    exec(1, 6, 0, 7, 5'b00010, 8'h01);
    exec(1, 7, 0, 0, 5'b00110, 8'h00);
    exec(1, 0, 6, 0, 5'b00101, 8'h00);
    exec(1, 6, 0, 0, 5'b11000, 8'h00);
    exec(1, 0, 0, 0, 5'b10000, 8'h01);
    exec(1, 0, 0, 0, 5'b00001, 8'hFF);

    // R3 R6 R7 R8 R9: sweep every source pair for every code
    begin
      logic [4:0] ops [13] = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                               5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000,
                               5'b11000, 5'b00011, 5'b11111};
      for (int o = 0; o < 13; o++) begin
        for (int k = 1; k <= 7; k++) exec(1, 0, 0, k, 5'b00000, W'(k * 53 + o * 29));
        for (int sa = 0; sa < 8; sa++)
          for (int sb = 0; sb < 8; sb++)
            exec(1, sa, sb, (sa + sb * 3 + o) % 8, ops[o], W'(sa * 37 + sb * 91 + o * 13));
        read_all("R4 R11 sweep state");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule